// File: doc/BRIEF.md
# Three-Phase Edge-Aligned PWM with Preloaded Compare Registers

This block produces three edge-aligned PWM phase signals from a free-running up-counter. A period compare register sets the length of the counting cycle, and one compare register per phase sets that phase's duty. Software reaches all four compare registers over an 8-bit register bus. Each register is made of a preload word, which software writes and reads, and an active value, which drives the counter and phase comparators. The active value takes the preload value at the update event, which fires as the counter wraps.

A 16-bit compare word is written as two bytes, the low byte first and the high byte second. The high-byte write completes the word and makes it eligible for transfer. In the wide mode the word holds a 13-bit value left-aligned, and that value is rounded up from the three discarded bits when the high byte arrives. In the narrow mode the high byte is the whole compare value. Three overflow bits can force individual phases to full duty in narrow mode, and each update event clears them.

Top module: `pwm3_top`

## Requirements
- R1: After reset the counter is 0, all phase compare values are 0, and the period value is 16. All phases are low, and reading addresses 0 and 1 returns 0x80 and 0x00.
- R2: The counter counts from 0 up to the active period value minus 1, then returns to 0. `update_o` is high during the cycle in which the counter holds its last value, and the transfers into the active values happen at the clock edge that ends that cycle.
- R3: A phase output is high while the counter is below that phase's active compare value and low otherwise. A compare value at or above the period therefore keeps the phase high for the whole period.
- R4: Register k (0 = period, 1..3 = phases U, V, W) has its low byte at address 2k and its high byte at address 2k+1. A low-byte write marks the register pending, and a high-byte write clears that mark. An update event copies the preload value into the active value only for registers that are not pending.
- R5: When an update event finds a register pending, its transfer is deferred. The active value then takes the new value at the clock edge of that register's high-byte write. A high-byte write that coincides with an update also loads the active value at once.
- R6: A read returns the preload word, never the active value. After a low-byte write the low byte reads back as written. After a high-byte write both bytes read back in the stored left-aligned form {value, 3'b000}.
- R7: In wide mode the stored value is written_word[15:3] + written_word[2], saturated at 8191. For example, 0x0104 is stored as 33 (0x0108), and 0xFFFC saturates to 0xFFF8.
- R8: In narrow mode the high byte written is the compare value itself, with no rounding. The stored word is {5'b0, byte, 3'b000}.
- R9: In narrow mode a set overflow bit forces its phase high. Each update event clears all overflow bits, and the clear takes priority over a write in the same cycle.
- R10: The control register is at address 8. Bit 0 selects narrow mode when set, and bits 1, 2 and 3 are the overflow bits for phases U, V and W. The register reads back the same layout. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address (write and read) |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pwm_o | output | 3 | Phase outputs, bit 0 = U, bit 1 = V, bit 2 = W |
| update_o | output | 1 | High in the last count of each period |

## Verification
The assertions assume that software never leaves a zero in the active period. They also assume that the counter step and wrap are checked only against a period that cannot shrink below the current count without a wrap, which the comparison on the incremented count absorbs. The stimulus keeps every period value between 3 and 41. It always writes a register low byte then high byte, with random reads placed in the gap, so that pending, deferred and coincident transfers all occur. Narrow and wide mode, and the overflow bits, are switched at random through the control register.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int CW   = 13;              // significant compare bits
  localparam int WW   = CW + 3;          // left-aligned word width
  localparam int DW   = 8;               // bus byte
  localparam int AW   = 4;
  localparam int NREG = 4;               // period + three phases
  localparam int NPH  = NREG - 1;
  localparam int RSW  = $clog2(NREG);
  localparam logic [AW-1:0] ADDR_CTRL = AW'(2 * NREG);

  typedef logic [CW-1:0] cmp_t;
endpackage

// File: rtl/pwm3_cmp_reg.sv
module pwm3_cmp_reg
  import pwm3_pkg::*;
#(
  parameter cmp_t RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          mode8_i,
  input  logic          update_i,
  output logic [WW-1:0] pre_o,
  output cmp_t          act_o,
  output logic          pend_o
);
  logic [WW-1:0] pre_q;
  cmp_t          act_q;
  logic          pend_q, defer_q;
  cmp_t          new_val;
  logic [CW:0]   sum;

  // round-up of the word formed by this high byte and the staged low byte
  always_comb begin
    sum = {1'b0, wdata_i, pre_q[7:3]} + {{CW{1'b0}}, pre_q[2]};
    if (mode8_i)     new_val = {{(CW-DW){1'b0}}, wdata_i};
    else if (sum[CW]) new_val = '1;
    else             new_val = sum[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= {RST_VAL, 3'b000};
      act_q   <= RST_VAL;
      pend_q  <= 1'b0;
      defer_q <= 1'b0;
    end else begin
      if (lo_we_i) begin
        pre_q[7:0] <= wdata_i;
        pend_q     <= 1'b1;
      end
      if (hi_we_i) begin
        pre_q   <= {new_val, 3'b000};
        pend_q  <= 1'b0;
        defer_q <= 1'b0;
        if (defer_q || update_i) act_q <= new_val;
      end else if (update_i) begin
        if (pend_q) defer_q <= 1'b1;
        else        act_q   <= pre_q[WW-1:3];
      end
    end
  end

  assign pre_o  = pre_q;
  assign act_o  = act_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter
  import pwm3_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmp_t per_i,
  output cmp_t cnt_o,
  output logic wrap_o
);
  cmp_t        cnt_q;
  logic [CW:0] nxt;

  assign nxt    = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  // >= keeps the wrap safe when a deferred load shortens the period mid-count
  assign wrap_o = nxt >= {1'b0, per_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= nxt[CW-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
  import pwm3_pkg::*;
(
  input  cmp_t cnt_i,
  input  cmp_t cmp_i,
  input  logic force_i,
  output logic pwm_o
);
  assign pwm_o = force_i | (cnt_i < cmp_i);
endmodule

// File: rtl/pwm3_top.sv
module pwm3_top
  import pwm3_pkg::*;
#(
  parameter int RST_PERIOD = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [NPH-1:0] pwm_o,
  output logic          update_o
);
  logic [NREG-1:0]    lo_we, hi_we, pend;
  logic [WW-1:0]      pre_w [NREG];
  cmp_t               act   [NREG];
  logic [NREG*CW-1:0] act_flat;
  cmp_t               cnt_q;
  logic               mode8_q;
  logic [NPH-1:0]     ovf_q;
  logic               ctrl_we;
  logic [WW-1:0]      rd_word;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign lo_we[g] = we_i && (addr_i == AW'(2 * g));
    assign hi_we[g] = we_i && (addr_i == AW'(2 * g + 1));

    pwm3_cmp_reg #(
      .RST_VAL((g == 0) ? cmp_t'(RST_PERIOD) : cmp_t'(0))
    ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lo_we_i (lo_we[g]),
      .hi_we_i (hi_we[g]),
      .wdata_i (wdata_i),
      .mode8_i (mode8_q),
      .update_i(update_o),
      .pre_o   (pre_w[g]),
      .act_o   (act[g]),
      .pend_o  (pend[g])
    );
    assign act_flat[g*CW +: CW] = act[g];
  end

  pwm3_counter u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .per_i (act[0]),
    .cnt_o (cnt_q),
    .wrap_o(update_o)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    pwm3_phase u_ph (
      .cnt_i  (cnt_q),
      .cmp_i  (act[g+1]),
      .force_i(mode8_q & ovf_q[g]),
      .pwm_o  (pwm_o[g])
    );
  end

  assign ctrl_we = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode8_q <= 1'b0;
      ovf_q   <= '0;
    end else begin
      if (ctrl_we) begin
        mode8_q <= wdata_i[0];
        ovf_q   <= wdata_i[NPH:1];
      end
      if (update_o) ovf_q <= '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    rd_word = pre_w[addr_i[RSW:1]];
    if (addr_i < ADDR_CTRL)
      rdata_o = addr_i[0] ? rd_word[WW-1:DW] : rd_word[DW-1:0];
    else if (addr_i == ADDR_CTRL)
      rdata_o = {{(DW-NPH-1){1'b0}}, ovf_q, mode8_q};
  end
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk
  import pwm3_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               update_i,
  input cmp_t               cnt_i,
  input cmp_t               per_i,
  input logic               mode8_i,
  input logic [NPH-1:0]     ovf_i,
  input logic [NPH-1:0]     pwm_i,
  input logic [NREG-1:0]    pend_i,
  input logic [NREG-1:0]    hi_we_i,
  input logic [NREG*CW-1:0] act_i
);
  AST_PER_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_i != '0); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> cnt_i == '0); // R2
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> cnt_i == $past(cnt_i) + cmp_t'(1)); // R2
  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> ovf_i == '0); // R9

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    AST_FORCE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode8_i && ovf_i[g]) |-> pwm_i[g]); // R9
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    AST_HOLD_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[g] && !hi_we_i[g]) |=> $stable(act_i[g*CW +: CW])); // R4
  end
endmodule

bind pwm3_top pwm3_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .update_i(update_o),
  .cnt_i   (cnt_q),
  .per_i   (act[0]),
  .mode8_i (mode8_q),
  .ovf_i   (ovf_q),
  .pwm_i   (pwm_o),
  .pend_i  (pend),
  .hi_we_i (hi_we),
  .act_i   (act_flat)
);

// File: tb/pwm3_top_tb.sv
`timescale 1ns/1ps
module pwm3_top_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] pwm_o;
  logic       update_o;

  always #5 clk = ~clk;

  pwm3_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o), .update_o(update_o)
  );

  // reference model
  logic [15:0] m_pre [4];
  logic [12:0] m_act [4];
  logic        m_pend [4];
  logic        m_defer [4];
  logic        m_mode8;
  logic [2:0]  m_ovf;
  logic [12:0] m_cnt;

  int    n_chk = 0, n_fail = 0;
  string cur_tag = "R1";
  logic [7:0] s_rd;
  logic [2:0] s_pwm;
  logic       s_upd;

  function automatic logic [12:0] f_new(logic m8, logic [7:0] hi, logic [7:0] lo);
    int s;
    if (m8) return {5'b0, hi};
    s = int'({hi, lo[7:3]}) + int'(lo[2]);
    if (s > 8191) s = 8191;
    return 13'(s);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %h expected %h", tag, cur_tag, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [3:0] a, logic [7:0] d);
    logic exp_upd;
    logic [2:0] exp_pwm;
    logic [7:0] exp_rd;
    logic [12:0] nv;
    logic [15:0] pre_old;
    logic p_old;
    @(negedge clk);
    we_i = we; addr_i = a; wdata_i = d;
    #1;
    exp_upd = (int'(m_cnt) + 1 >= int'(m_act[0]));
    for (int i = 0; i < 3; i++)
      exp_pwm[i] = (m_mode8 && m_ovf[i]) || (m_cnt < m_act[i+1]);
    if (a < 4'd8)      exp_rd = a[0] ? m_pre[a[2:1]][15:8] : m_pre[a[2:1]][7:0];
    else if (a == 4'd8) exp_rd = {4'b0, m_ovf, m_mode8};
    else               exp_rd = 8'h00;
    s_rd = rdata_o; s_pwm = pwm_o; s_upd = update_o;
    check("R2", {15'b0, s_upd}, {15'b0, exp_upd});
    check("R3", {13'b0, s_pwm}, {13'b0, exp_pwm});
    check("R6", {8'b0, s_rd}, {8'b0, exp_rd});
    // next state
    for (int k = 0; k < 4; k++) begin
      pre_old = m_pre[k];
      p_old   = m_pend[k];
      nv      = f_new(m_mode8, d, pre_old[7:0]);
      if (we && a == 4'(2*k)) begin
        m_pre[k][7:0] = d;
        m_pend[k] = 1'b1;
      end
      if (we && a == 4'(2*k+1)) begin
        m_pre[k]  = {nv, 3'b000};
        m_pend[k] = 1'b0;
        if (m_defer[k] || exp_upd) m_act[k] = nv;
        m_defer[k] = 1'b0;
      end else if (exp_upd) begin
        if (p_old) m_defer[k] = 1'b1;
        else       m_act[k] = pre_old[15:3];
      end
    end
    if (we && a == 4'd8) begin
      m_mode8 = d[0];
      m_ovf   = d[3:1];
    end
    if (exp_upd) m_ovf = '0;
    m_cnt = exp_upd ? 13'd0 : m_cnt + 13'd1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'(i % 10), 8'h00);
  endtask

  task automatic wait_upd();
    s_upd = 1'b0;
    while (!s_upd) cyc(1'b0, 4'd8, 8'h00);
  endtask

  task automatic wr_word(int k, logic [15:0] w, int gap);
    cyc(1'b1, 4'(2*k), w[7:0]);
    for (int i = 0; i < gap; i++) cyc(1'b0, 4'($urandom % 11), 8'h00);
    cyc(1'b1, 4'(2*k+1), w[15:8]);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k, v;
    logic [15:0] w;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin
      m_pre[i] = (i == 0) ? 16'h0080 : 16'h0000;
      m_act[i] = (i == 0) ? 13'd16 : 13'd0;
      m_pend[i] = 1'b0;
      m_defer[i] = 1'b0;
    end
    m_mode8 = 1'b0; m_ovf = '0; m_cnt = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    cur_tag = "R1";
    cyc(1'b0, 4'd0, 8'h00);
    check("R1", {8'b0, s_rd}, 16'h0080);
    check("R1", {13'b0, s_pwm}, 16'h0000);
    cyc(1'b0, 4'd1, 8'h00);
    check("R1", {8'b0, s_rd}, 16'h0000);

    // R6 low byte readback, R7 round-up and saturation
    cur_tag = "R7";
    cyc(1'b1, 4'd2, 8'h04);
    cyc(1'b0, 4'd2, 8'h00);
    check("R6", {8'b0, s_rd}, 16'h0004);
    cyc(1'b1, 4'd3, 8'h01);
    cyc(1'b0, 4'd2, 8'h00);
    check("R7", {8'b0, s_rd}, 16'h0008);
    cyc(1'b0, 4'd3, 8'h00);
    check("R7", {8'b0, s_rd}, 16'h0001);
    wr_word(2, 16'hFFFC, 0);
    cyc(1'b0, 4'd4, 8'h00);
    check("R7", {8'b0, s_rd}, 16'h00F8);
    cyc(1'b0, 4'd5, 8'h00);
    check("R7", {8'b0, s_rd}, 16'h00FF);

    // R3 compare above period: full duty after update
    cur_tag = "R3";
    wait_upd();
    idle(5);
    check("R3", {13'b0, s_pwm}, 16'h0003);

    // R4 pending blocks transfer across updates
    cur_tag = "R4";
    cyc(1'b1, 4'd6, 8'h60);
    wait_upd();
    idle(20);
    check("R4", {13'b0, s_pwm & 3'b100}, 16'h0000);
    // R5 deferred transfer takes effect at the high-byte write
    cur_tag = "R5";
    cyc(1'b1, 4'd7, 8'h00);
    idle(20);
    wait_upd();
    cyc(1'b0, 4'd0, 8'h00);
    check("R5", {13'b0, s_pwm & 3'b100}, 16'h0004);

    // R10 control readback, R8 narrow write
    cur_tag = "R10";
    cyc(1'b1, 4'd8, 8'h01);
    cyc(1'b0, 4'd8, 8'h00);
    check("R10", {8'b0, s_rd}, 16'h0001);
    cyc(1'b0, 4'd12, 8'h00);
    check("R10", {8'b0, s_rd}, 16'h0000);
    cur_tag = "R8";
    cyc(1'b1, 4'd0, 8'h55);
    cyc(1'b0, 4'd0, 8'h00);
    check("R6", {8'b0, s_rd}, 16'h0055);
    cyc(1'b1, 4'd1, 8'd10);
    cyc(1'b0, 4'd0, 8'h00);
    check("R8", {8'b0, s_rd}, 16'h0050);
    cyc(1'b0, 4'd1, 8'h00);
    check("R8", {8'b0, s_rd}, 16'h0000);

    // R9 overflow force on phase W, then cleared by update
    cur_tag = "R9";
    wr_word(3, 16'h0000, 0);
    wait_upd();
    cyc(1'b1, 4'd8, 8'h09);
    cyc(1'b0, 4'd8, 8'h00);
    check("R9", {8'b0, s_rd}, 16'h0009);
    check("R9", {15'b0, s_pwm[2]}, 16'h0001);
    wait_upd();
    cyc(1'b0, 4'd8, 8'h00);
    check("R9", {8'b0, s_rd}, 16'h0001);
    check("R9", {15'b0, s_pwm[2]}, 16'h0000);

    // constrained random traffic
    cur_tag = "RND";
    for (int it = 0; it < 1500; it++) begin
      k = $urandom % 5;
      if (k == 4) begin
        cyc(1'b1, 4'd8, 8'($urandom % 16));
      end else begin
        v = (k == 0) ? 3 + ($urandom % 38) : ($urandom % 51);
        if (m_mode8) w = {8'(v), 8'($urandom)};
        else         w = 16'(v * 8 + ($urandom % 8));
        wr_word(k, w, $urandom % 4);
      end
      idle($urandom % 4);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule